// File: doc/BRIEF.md
# Output Compare Timer Channel

This block is a single timer channel. A free-running up-counter advances once per clock while both the run bit and the clock-enable input are high. The counter keeps going through compare events. On every counting cycle it is compared with a compare register. On equality the channel latches a sticky event flag, can raise an interrupt request, and can toggle a compare output pin.

Software programs the channel through a simple write-only register port. There are four word addresses: control, compare value, step and flag clear. For periodic events the channel can rearm itself. When reload is enabled, the hardware adds the step to the compare register on the cycle after each event, modulo 2^16. Successive events are then exactly one step apart, and no software service deadline applies. Without reload, software rewrites the compare value itself. A value the counter has already passed only produces an event after the counter has wrapped all the way round.

Top module: `oc_timer_chan`

## Requirements
- R1: The counter resets to 0. It increments by one on each clock edge where control bit 0 (run) and `cnt_en_i` are both high, wraps from 0xFFFF to 0x0000, and otherwise holds its value.
- R2: An event occurs in a cycle where the counter is advancing and equals the compare register. The flag is set from the next edge, and `irq_o` is high whenever the flag is set and control bit 1 (interrupt enable) is set.
- R3: With reload off and the compare register untouched, a second event follows the first exactly 65536 counting cycles later.
- R4: With control bit 3 (reload) set, the compare register becomes compare + step, modulo 2^16, on the edge after each event. Successive events are then step counting cycles apart.
- R5: The flag stays set until a write to address 3 with data bit 0 set. A write there with bit 0 clear has no effect. An event in the same cycle as a clear leaves the flag set.
- R6: With control bit 2 (pin enable) set, `cmp_pin_o` toggles on the edge after each event. Otherwise the pin holds its value.
- R7: A compare value written at address 1 that lies 3 counts behind the current count produces its event 65533 counting cycles after the write cycle.
- R8: A compare write at address 1 in the same cycle as an event with reload on takes the written value and discards the reload sum. The step register is written at address 2, and the low four data bits are written to control at address 0.
- R9: Asynchronous reset clears the counter, control, compare, step, flag and pin, so nothing counts until run is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word address |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Interrupt request |
| cmp_pin_o | output | 1 | Compare output pin |

## Verification
The hardest case to reach from the ports is a compare write that lands in the very cycle of an event while reload is active. A second hard case is an event coinciding with a flag clear. Both need the stimulus to know which cycle the counter will equal the compare value. The bench keeps a cycle-accurate model of count and compare, idles until the model shows equality in the coming cycle, and issues the write in exactly that cycle. It then measures the pin-toggle interval to tell the written value from the reload sum. The full-wrap cases (an untouched compare, and a late write) are reached by letting the counter run a complete lap and timing the next interrupt.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  localparam int ADDR_W = 2;
  localparam int NREG   = 2 ** ADDR_W;
  localparam int CTRL_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMP  = 2'd1,
    ADDR_STEP = 2'd2,
    ADDR_FLAG = 2'd3
  } reg_addr_e;

  // bit 3 .. bit 0
  typedef struct packed {
    logic auto_rl;
    logic pin_en;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (tick_i) count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/oc_cmp_unit.sv
module oc_cmp_unit #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] count_i,
  input  logic         tick_i,
  input  logic         auto_i,
  input  logic         cmp_wr_i,
  input  logic         step_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         match_o,
  output logic [W-1:0] cmp_o,
  output logic [W-1:0] step_o
);

  logic [W-1:0] sum;

  // only a cycle that advances the counter can match, so a stalled counter fires once
  assign match_o = tick_i && (count_i == cmp_o);
  assign sum     = cmp_o + step_o;  // carry dropped: modulo 2^W

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o  <= '0;
      step_o <= '0;
    end else begin
      if (cmp_wr_i)               cmp_o <= wdata_i;  // bus write beats reload
      else if (match_o && auto_i) cmp_o <= sum;
      if (step_wr_i)              step_o <= wdata_i;
    end
  end

endmodule

// File: rtl/oc_event.sv
module oc_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic clr_i,
  input  logic irq_en_i,
  input  logic pin_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic pin_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      pin_o  <= 1'b0;
    end else begin
      if (match_i)    flag_o <= 1'b1;  // set wins over clear
      else if (clr_i) flag_o <= 1'b0;
      if (match_i && pin_en_i) pin_o <= ~pin_o;
    end
  end

  assign irq_o = flag_o & irq_en_i;

endmodule

// File: rtl/oc_timer_chan.sv
module oc_timer_chan
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o,
  output logic              cmp_pin_o
);

  logic [NREG-1:0]  wr_sel;
  ctrl_t            ctrl_q;
  logic             ctrl_wr, cmp_wr, step_wr, flag_clr;
  logic             tick, match, flag_q;
  logic [CNT_W-1:0] cmp_q, step_q;

  assign wr_sel   = wr_en_i ? (NREG'(1) << wr_addr_i) : '0;
  assign ctrl_wr  = wr_sel[ADDR_CTRL];
  assign cmp_wr   = wr_sel[ADDR_CMP];
  assign step_wr  = wr_sel[ADDR_STEP];
  assign flag_clr = wr_sel[ADDR_FLAG] & wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  assign tick = ctrl_q.run & cnt_en_i;

  oc_counter #(.W(CNT_W)) cnt_u (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .count_o (count_o)
  );

  oc_cmp_unit #(.W(CNT_W)) cmp_u (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count_o),
    .tick_i    (tick),
    .auto_i    (ctrl_q.auto_rl),
    .cmp_wr_i  (cmp_wr),
    .step_wr_i (step_wr),
    .wdata_i   (wr_data_i),
    .match_o   (match),
    .cmp_o     (cmp_q),
    .step_o    (step_q)
  );

  oc_event evt_u (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match),
    .clr_i    (flag_clr),
    .irq_en_i (ctrl_q.irq_en),
    .pin_en_i (ctrl_q.pin_en),
    .flag_o   (flag_q),
    .irq_o    (irq_o),
    .pin_o    (cmp_pin_o)
  );

endmodule

// File: rtl/oc_timer_chan_chk.sv
module oc_timer_chan_chk
  import oc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         match_i,
  input ctrl_t        ctrl_i,
  input logic         ctrl_wr_i,
  input logic         cmp_wr_i,
  input logic         clr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] cmp_i,
  input logic [W-1:0] step_i,
  input logic         flag_i,
  input logic         irq_i,
  input logic         pin_i
);

  logic [W-1:0] nxt_cmp;
  assign nxt_cmp = cmp_i + step_i;

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> count_i == W'($past(count_i) + 1'b1));

  assert_count_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_i));

  assert_event_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && ctrl_i.irq_en && !ctrl_wr_i |=> irq_i);

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && ctrl_i.auto_rl && !cmp_wr_i |=> cmp_i == $past(nxt_cmp));

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !clr_i |=> flag_i);

  assert_flag_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i && !match_i |=> !flag_i);

  assert_pin_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && ctrl_i.pin_en |=> pin_i != $past(pin_i));

  assert_pin_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_i && ctrl_i.pin_en) |=> $stable(pin_i));

  assert_wr_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr_i |=> cmp_i == $past(wdata_i));

endmodule

bind oc_timer_chan oc_timer_chan_chk #(.W(CNT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .match_i   (match),
  .ctrl_i    (ctrl_q),
  .ctrl_wr_i (ctrl_wr),
  .cmp_wr_i  (cmp_wr),
  .clr_i     (flag_clr),
  .wdata_i   (wr_data_i),
  .count_i   (count_o),
  .cmp_i     (cmp_q),
  .step_i    (step_q),
  .flag_i    (flag_q),
  .irq_i     (irq_o),
  .pin_i     (cmp_pin_o)
);

// File: tb/oc_timer_chan_tb_top.sv
`timescale 1ns/1ps
module oc_timer_chan_tb_top;

  localparam logic [1:0] A_CTRL = 2'd0, A_CMP = 2'd1, A_STEP = 2'd2, A_FLAG = 2'd3;

  logic        clk = 1'b0, rst_ni = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        irq, pin;

  always #10 clk = ~clk;  // 50 MHz

  oc_timer_chan dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cnt_en_i  (cnt_en),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .count_o   (count),
    .irq_o     (irq),
    .cmp_pin_o (pin)
  );

  int n_cmp = 0, n_bad = 0, cyc_no = 0;

  // reference model state
  logic [15:0] m_cnt, m_cmp, m_step;
  logic [3:0]  m_ctrl;
  logic        m_flag, m_pin;

  function automatic logic [15:0] reload_val(logic [15:0] c, logic [15:0] s);
    return c + s;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_cmp = '0; m_step = '0; m_ctrl = '0; m_flag = 1'b0; m_pin = 1'b0;
  endtask

  task automatic model_step();
    logic tk, mt;
    tk = m_ctrl[0] && cnt_en;
    mt = tk && (m_cnt == m_cmp);
    if (wr_en && wr_addr == A_CMP) m_cmp = wr_data;
    else if (mt && m_ctrl[3])      m_cmp = reload_val(m_cmp, m_step);
    if (wr_en && wr_addr == A_STEP) m_step = wr_data;
    if (mt && m_ctrl[2]) m_pin = ~m_pin;
    if (mt) m_flag = 1'b1;
    else if (wr_en && wr_addr == A_FLAG && wr_data[0]) m_flag = 1'b0;
    if (wr_en && wr_addr == A_CTRL) m_ctrl = wr_data[3:0];
    if (tk) m_cnt = m_cnt + 16'd1;
  endtask

  task automatic cyc(bit we, logic [1:0] a, logic [15:0] d, bit ce);
    wr_en = we; wr_addr = a; wr_data = d; cnt_en = ce;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc_no++;
    wr_en = 1'b0;
    check_eq("R1", "count", int'(count), int'(m_cnt));
    check_eq("R2", "irq", int'(irq), int'(m_flag & m_ctrl[1]));
    check_eq("R6", "pin", int'(pin), int'(m_pin));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, A_CTRL, 16'd0, 1'b1);
  endtask

  task automatic wait_irq(output int t);
    do cyc(1'b0, A_CTRL, 16'd0, 1'b1); while (!irq);
    t = cyc_no;
  endtask

  task automatic wait_pin(output int t);
    logic p0;
    p0 = pin;
    do cyc(1'b0, A_CTRL, 16'd0, 1'b1); while (pin == p0);
    t = cyc_no;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t_a, t_b, t_w, t1, t2, t3;
    logic [15:0] c, exp_c;
    void'($urandom(32'd41077));
    model_reset();
    repeat (3) @(negedge clk);
    check_eq("R9", "count in reset", int'(count), 0);
    check_eq("R9", "irq in reset", int'(irq), 0);
    check_eq("R9", "pin in reset", int'(pin), 0);
    rst_ni = 1'b1;

    // R9: run bit clear after reset, counter idle
    idle(3);
    check_eq("R9", "count idle after reset", int'(count), 0);

    // R1: counting and hold
    cyc(1'b1, A_CTRL, 16'h0001, 1'b1);
    idle(10);
    check_eq("R1", "count after 10 ticks", int'(count), 10);
    for (int i = 0; i < 5; i++) cyc(1'b0, A_CTRL, 16'd0, 1'b0);
    check_eq("R1", "count held by cnt_en_i", int'(count), 10);

    // R2/R5/R6: first event, clear in the event cycle loses
    cyc(1'b1, A_CTRL, 16'h0007, 1'b1);
    exp_c = m_cnt + 16'd20;
    cyc(1'b1, A_CMP, exp_c, 1'b1);
    while (m_cnt != exp_c) idle(1);
    cyc(1'b1, A_FLAG, 16'h0001, 1'b1);
    t_a = cyc_no;
    check_eq("R5", "irq after clear in event cycle", int'(irq), 1);
    check_eq("R2", "count after event", int'(count), int'(exp_c + 16'd1));
    idle(5);
    check_eq("R5", "flag sticky", int'(irq), 1);
    cyc(1'b1, A_FLAG, 16'h0000, 1'b1);
    check_eq("R5", "clear with bit0 low", int'(irq), 1);
    cyc(1'b1, A_FLAG, 16'h0001, 1'b1);
    check_eq("R5", "clear with bit0 high", int'(irq), 0);
    check_eq("R6", "pin after first event", int'(pin), 1);

    // R3: untouched compare fires again one lap later
    wait_irq(t_b);
    check_eq("R3", "lap interval", t_b - t_a, 65536);
    check_eq("R6", "pin after second event", int'(pin), 0);
    cyc(1'b1, A_FLAG, 16'h0001, 1'b1);

    // R7: compare written behind the counter
    c = m_cnt;
    cyc(1'b1, A_CMP, c - 16'd3, 1'b1);
    t_w = cyc_no;
    wait_irq(t1);
    check_eq("R7", "late write delay", t1 - t_w, 65533);
    cyc(1'b1, A_FLAG, 16'h0001, 1'b1);

    // R4: hardware reload interval
    cyc(1'b1, A_STEP, 16'd100, 1'b1);
    cyc(1'b1, A_CTRL, 16'h000D, 1'b1);
    cyc(1'b1, A_CMP, m_cnt + 16'd10, 1'b1);
    wait_pin(t1);
    wait_pin(t2);
    wait_pin(t3);
    check_eq("R4", "reload interval 1", t2 - t1, 100);
    check_eq("R4", "reload interval 2", t3 - t2, 100);

    // R8: bus write in the event cycle beats reload
    while (m_cnt != m_cmp) idle(1);
    cyc(1'b1, A_CMP, m_cnt + 16'd50, 1'b1);
    t_w = cyc_no;
    wait_pin(t1);
    check_eq("R8", "written compare wins", t1 - t_w, 50);

    // mixed random traffic against the model
    for (int i = 0; i < 8000; i++) begin
      int r;
      bit ce;
      r  = $urandom_range(0, 15);
      ce = ($urandom_range(0, 7) != 0);
      case (r)
        0: cyc(1'b1, A_CTRL, 16'($urandom_range(0, 15)) | 16'h0001, ce);
        1: cyc(1'b1, A_CMP, m_cnt + 16'($urandom_range(0, 120)), ce);
        2: cyc(1'b1, A_STEP, 16'($urandom_range(0, 90)), ce);
        3: cyc(1'b1, A_FLAG, 16'($urandom_range(0, 1)), ce);
        default: cyc(1'b0, A_CTRL, 16'd0, ce);
      endcase
    end

    // R9: reset in mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    #1;
    check_eq("R9", "count after reset", int'(count), 0);
    check_eq("R9", "irq after reset", int'(irq), 0);
    check_eq("R9", "pin after reset", int'(pin), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(4);
    check_eq("R9", "counter idle after reset", int'(count), 0);

    summary();
    $finish;
  end

endmodule